// File: doc/BRIEF.md
# Big-Endian Load/Store Aligner

This block connects a 32-bit processor core to a 32-bit data memory port. For each access the core presents a byte address, a size code (8, 16 or 32 bits), a write flag and store data. The block turns this into a word-aligned memory address, four byte-lane enables and store data placed in the right lanes. When read data comes back it selects the addressed byte or halfword and widens it to 32 bits for the core.

Lanes are assigned big-endian: the lowest-addressed byte of a word travels on the most significant lane. A halfword at an odd address, a longword whose address is not a multiple of four, or the reserved size code is refused. The block raises an address-error pulse in the same cycle as the request, and no memory strobe or lane enable leaves the block. The memory is assumed to return read data one cycle after the read strobe. The block registers the size and the low address bits so that it can widen that returning word in the following cycle.

Top module: `bea_aligner`

## Requirements
- R1: While `mem_req` is high, `mem_addr` equals `cpu_addr` with bits 1:0 forced to zero.
- R2: Size code 2'b00 (byte) is accepted at every address. The byte at offset `cpu_addr[1:0]` = 0, 1, 2, 3 is enabled on `mem_be` bit 3, 2, 1, 0 respectively. Bit 3 covers data bits 31:24 and bit 0 covers bits 7:0.
- R3: Size code 2'b01 (halfword) with `cpu_addr[0]`=1, size code 2'b10 (longword) with `cpu_addr[1:0]`≠0, and size code 2'b11 at any address each raise `cpu_addr_err` in the request cycle.
- R4: When `cpu_addr_err` is high, `mem_req` is low and `mem_be` is 4'b0000. With `cpu_req` low, neither `cpu_addr_err` nor `mem_req` is raised, whatever the address.
- R5: A byte store copies `cpu_wdata[7:0]` onto all four lanes of `mem_wdata` and enables exactly one lane, as in R2.
- R6: A halfword access enables `mem_be`=4'b1100 at offset 0 and 4'b0011 at offset 2. A halfword store copies `cpu_wdata[15:0]` into both halves of `mem_wdata`.
- R7: A longword access enables all four lanes. A longword store passes `cpu_wdata` unchanged.
- R8: A byte load returns the addressed byte, taken from the lane given by R2, sign-extended to 32 bits.
- R9: A halfword load returns bits 31:16 of `mem_rdata` at offset 0 and bits 15:0 at offset 2, sign-extended to 32 bits.
- R10: A longword load returns `mem_rdata` unchanged.
- R11: `cpu_rvalid` rises in the cycle after an accepted read and in no other cycle. It stays low after writes and refused accesses, and an asynchronous reset clears it at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Access request from the core |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_size | input | 2 | 00 byte, 01 halfword, 10 longword, 11 reserved |
| cpu_addr | input | AW | Byte address |
| cpu_wdata | input | 32 | Store data, right-justified |
| cpu_rdata | output | 32 | Widened load data, valid with `cpu_rvalid` |
| cpu_rvalid | output | 1 | Load data valid |
| cpu_addr_err | output | 1 | Address-error pulse for a refused access |
| mem_req | output | 1 | Memory strobe |
| mem_we | output | 1 | Memory write |
| mem_addr | output | AW | Word-aligned memory address |
| mem_be | output | 4 | Byte-lane enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Lane-positioned store data |
| mem_rdata | input | 32 | Raw read word, one cycle after a read strobe |

## Verification
The properties assume that the memory answers every read strobe with valid data in exactly the next cycle. They also assume that the core holds `cpu_size` and `cpu_addr` at known values whenever `cpu_req` is high. The width checks on loaded data compare against the size seen one cycle earlier, so they only hold if no other agent changes `mem_rdata` timing. The bench drives its requests from one loop at the falling edge and keeps them steady for a whole cycle. It answers with a one-cycle synchronous memory model, so the stimulus stays inside those assumptions.

// File: rtl/bea_pkg.sv
package bea_pkg;

  localparam int DW    = 32;
  localparam int LANES = DW / 8;
  localparam int OFFW  = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_FULL = 2'b10,
    SZ_BAD  = 2'b11
  } size_e;

  // Refusal rule: halfword needs an even offset, longword a zero offset.
  function automatic logic size_fault(size_e sz, logic [OFFW-1:0] off);
    case (sz)
      SZ_BYTE: size_fault = 1'b0;
      SZ_HALF: size_fault = off[0];
      SZ_FULL: size_fault = |off;
      default: size_fault = 1'b1;
    endcase
  endfunction

  // Big-endian lane enables: offset 0 maps to the top lane.
  function automatic logic [LANES-1:0] lane_mask(size_e sz, logic [OFFW-1:0] off);
    case (sz)
      SZ_BYTE: lane_mask = LANES'(1 << (LANES - 1 - int'(off)));
      SZ_HALF: lane_mask = off[1] ? 4'b0011 : 4'b1100;
      SZ_FULL: lane_mask = '1;
      default: lane_mask = '0;
    endcase
  endfunction

  function automatic logic [DW-1:0] sext8(logic [7:0] b);
    sext8 = {{(DW-8){b[7]}}, b};
  endfunction

  function automatic logic [DW-1:0] sext16(logic [15:0] h);
    sext16 = {{(DW-16){h[15]}}, h};
  endfunction

endpackage

// File: rtl/bea_align_check.sv
module bea_align_check
  import bea_pkg::*;
(
  input  logic            req_i,
  input  size_e           size_i,
  input  logic [OFFW-1:0] off_i,
  output logic            fault_o,
  output logic            go_o
);

  logic fault_raw;

  always_comb begin
    fault_raw = size_fault(size_i, off_i);
    fault_o   = req_i & fault_raw;
    go_o      = req_i & ~fault_raw;
  end

endmodule

// File: rtl/bea_store_lanes.sv
module bea_store_lanes
  import bea_pkg::*;
(
  input  logic             en_i,
  input  size_e            size_i,
  input  logic [OFFW-1:0]  off_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [LANES-1:0] be_o,
  output logic [DW-1:0]    wdata_o
);

  assign be_o = en_i ? lane_mask(size_i, off_i) : '0;

  // Each lane picks its source byte by size: the low byte for byte stores,
  // the matching byte of the low halfword for halfword stores, itself for full.
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int HB = i % 2;
    always_comb begin
      case (size_i)
        SZ_BYTE: wdata_o[8*i +: 8] = wdata_i[7:0];
        SZ_HALF: wdata_o[8*i +: 8] = wdata_i[8*HB +: 8];
        default: wdata_o[8*i +: 8] = wdata_i[8*i +: 8];
      endcase
    end
  end

endmodule

// File: rtl/bea_load_widen.sv
module bea_load_widen
  import bea_pkg::*;
(
  input  logic            vld_i,
  input  size_e           size_i,
  input  logic [OFFW-1:0] off_i,
  input  logic [DW-1:0]   rdata_i,
  output logic [DW-1:0]   rdata_o
);

  // lane_b[k] holds the byte at address offset k (big-endian order).
  logic [7:0] lane_b [LANES];

  for (genvar k = 0; k < LANES; k++) begin : g_pick
    assign lane_b[k] = rdata_i[8*(LANES-1-k) +: 8];
  end

  logic [15:0] half_sel;
  logic [DW-1:0] widened;

  always_comb begin
    half_sel = off_i[1] ? {lane_b[2], lane_b[3]} : {lane_b[0], lane_b[1]};
    case (size_i)
      SZ_BYTE: widened = sext8(lane_b[off_i]);
      SZ_HALF: widened = sext16(half_sel);
      default: widened = rdata_i;
    endcase
    rdata_o = vld_i ? widened : '0;
  end

endmodule

// File: rtl/bea_aligner.sv
module bea_aligner
  import bea_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [1:0]    cpu_size,
  input  logic [AW-1:0] cpu_addr,
  input  logic [31:0]   cpu_wdata,
  output logic [31:0]   cpu_rdata,
  output logic          cpu_rvalid,
  output logic          cpu_addr_err,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata
);

  size_e           req_size;
  logic [OFFW-1:0] req_off;
  logic            acc_fault;
  logic            acc_go;
  logic            rd_go;

  size_e           size_q;
  logic [OFFW-1:0] off_q;
  logic            rd_pend;

  assign req_size = size_e'(cpu_size);
  assign req_off  = cpu_addr[OFFW-1:0];

  bea_align_check u_check (
    .req_i   (cpu_req),
    .size_i  (req_size),
    .off_i   (req_off),
    .fault_o (acc_fault),
    .go_o    (acc_go)
  );

  assign rd_go        = acc_go & ~cpu_we;
  assign cpu_addr_err = acc_fault;
  assign mem_req      = acc_go;
  assign mem_we       = acc_go & cpu_we;
  assign mem_addr     = {cpu_addr[AW-1:OFFW], {OFFW{1'b0}}};

  bea_store_lanes u_store (
    .en_i    (acc_go),
    .size_i  (req_size),
    .off_i   (req_off),
    .wdata_i (cpu_wdata),
    .be_o    (mem_be),
    .wdata_o (mem_wdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend <= 1'b0;
      size_q  <= SZ_BYTE;
      off_q   <= '0;
    end else begin
      rd_pend <= rd_go;
      if (rd_go) begin
        size_q <= req_size;
        off_q  <= req_off;
      end
    end
  end

  bea_load_widen u_load (
    .vld_i   (rd_pend),
    .size_i  (size_q),
    .off_i   (off_q),
    .rdata_i (mem_rdata),
    .rdata_o (cpu_rdata)
  );

  assign cpu_rvalid = rd_pend;

endmodule

// File: rtl/bea_aligner_checker.sv
module bea_aligner_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_req,
  input logic          cpu_we,
  input logic [1:0]    cpu_size,
  input logic [AW-1:0] cpu_addr,
  input logic [31:0]   cpu_rdata,
  input logic          cpu_rvalid,
  input logic          cpu_addr_err,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic [3:0]    mem_be,
  input logic          acc_fault,
  input logic          acc_go,
  input logic          rd_go
);

  a_r1_word_addr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00 && mem_addr[AW-1:2] == cpu_addr[AW-1:2]));

  a_r2_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_size == 2'b00) |-> (!cpu_addr_err && $countones(mem_be) == 1));

  a_r3_half_odd: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_size == 2'b01 && cpu_addr[0]) |-> cpu_addr_err);

  a_r3_full_unaligned: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_size == 2'b10 && cpu_addr[1:0] != 2'b00) |-> cpu_addr_err);

  a_r3_reserved_size: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_size == 2'b11) |-> cpu_addr_err);

  a_r4_fault_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fault |-> (!mem_req && mem_be == 4'b0000 && !acc_go));

  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_req |-> (!cpu_addr_err && !mem_req));

  a_r6_half_two_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && cpu_size == 2'b01) |-> $countones(mem_be) == 2);

  a_r7_full_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && cpu_size == 2'b10) |-> mem_be == 4'b1111);

  a_r8_byte_sext: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rvalid && $past(cpu_size) == 2'b00) |-> cpu_rdata[31:8] == {24{cpu_rdata[7]}});

  a_r9_half_sext: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rvalid && $past(cpu_size) == 2'b01) |-> cpu_rdata[31:16] == {16{cpu_rdata[15]}});

  a_r11_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> cpu_rvalid);

  a_r11_rvalid_only_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_req && !cpu_we && !cpu_addr_err) |=> !cpu_rvalid);

endmodule

bind bea_aligner bea_aligner_checker #(.AW(AW)) u_bea_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpu_req      (cpu_req),
  .cpu_we       (cpu_we),
  .cpu_size     (cpu_size),
  .cpu_addr     (cpu_addr),
  .cpu_rdata    (cpu_rdata),
  .cpu_rvalid   (cpu_rvalid),
  .cpu_addr_err (cpu_addr_err),
  .mem_req      (mem_req),
  .mem_addr     (mem_addr),
  .mem_be       (mem_be),
  .acc_fault    (acc_fault),
  .acc_go       (acc_go),
  .rd_go        (rd_go)
);

// File: tb/test_bea_aligner.sv
`timescale 1ns/1ps
module test_bea_aligner;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_req = 1'b0;
  logic          cpu_we = 1'b0;
  logic [1:0]    cpu_size = 2'b00;
  logic [AW-1:0] cpu_addr = '0;
  logic [31:0]   cpu_wdata = '0;
  logic [31:0]   cpu_rdata;
  logic          cpu_rvalid;
  logic          cpu_addr_err;
  logic          mem_req;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [3:0]    mem_be;
  logic [31:0]   mem_wdata;
  logic [31:0]   mem_rdata = '0;

  always #2 clk = ~clk;

  bea_aligner #(.AW(AW)) i_bea_aligner (.*);

  // One-cycle synchronous memory, 4 words.
  logic [31:0] words [4];
  initial for (int i = 0; i < 4; i++) words[i] = '0;
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        for (int l = 0; l < 4; l++)
          if (mem_be[l]) words[mem_addr[3:2]][8*l +: 8] <= mem_wdata[8*l +: 8];
      end else begin
        mem_rdata <= words[mem_addr[3:2]];
      end
    end
  end

  // Byte-addressed reference image, kept by the bench alone.
  logic [7:0] img [16];
  initial for (int i = 0; i < 16; i++) img[i] = 8'h00;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_store(logic [1:0] sz, logic [31:0] d);
    if (sz == 2'b00) return {d[7:0], d[7:0], d[7:0], d[7:0]};
    if (sz == 2'b01) return {d[15:0], d[15:0]};
    return d;
  endfunction

  function automatic logic [31:0] exp_load(logic [1:0] sz, logic [7:0] a);
    logic [31:0] v;
    if (sz == 2'b00) begin
      v = {24'h0, img[a[3:0]]};
      if (v[7]) v[31:8] = 24'hFFFFFF;
    end else if (sz == 2'b01) begin
      v = {16'h0, img[a[3:0]], img[a[3:0] + 4'd1]};
      if (v[15]) v[31:16] = 16'hFFFF;
    end else begin
      v = {img[a[3:0]], img[a[3:0] + 4'd1], img[a[3:0] + 4'd2], img[a[3:0] + 4'd3]};
    end
    return v;
  endfunction

  // {we, size, addr[7:0], wdata, expected be, expected err}
  localparam int NV = 21;
  localparam logic [47:0] VEC [NV] = '{
    {1'b1, 2'b10, 8'h00, 32'h8899AABB, 4'b1111, 1'b0},  // R7 long store
    {1'b1, 2'b00, 8'h05, 32'h000000F1, 4'b0100, 1'b0},  // R5 byte off1
    {1'b1, 2'b00, 8'h04, 32'h55555512, 4'b1000, 1'b0},  // R5 byte off0
    {1'b1, 2'b01, 8'h06, 32'hEEEEC3D4, 4'b0011, 1'b0},  // R6 half off2
    {1'b1, 2'b10, 8'h09, 32'hDEADBEEF, 4'b0000, 1'b1},  // R3 long off1
    {1'b1, 2'b01, 8'h03, 32'h0000BEEF, 4'b0000, 1'b1},  // R3 half odd
    {1'b0, 2'b10, 8'h00, 32'h0,        4'b1111, 1'b0},  // R10
    {1'b0, 2'b00, 8'h01, 32'h0,        4'b0100, 1'b0},  // R8 neg
    {1'b0, 2'b00, 8'h04, 32'h0,        4'b1000, 1'b0},  // R8 pos
    {1'b0, 2'b00, 8'h05, 32'h0,        4'b0100, 1'b0},  // R8
    {1'b0, 2'b01, 8'h06, 32'h0,        4'b0011, 1'b0},  // R9 low half
    {1'b0, 2'b01, 8'h00, 32'h0,        4'b1100, 1'b0},  // R9 high half
    {1'b0, 2'b01, 8'h02, 32'h0,        4'b0011, 1'b0},  // R9
    {1'b0, 2'b11, 8'h00, 32'h0,        4'b0000, 1'b1},  // R3 reserved
    {1'b0, 2'b10, 8'h02, 32'h0,        4'b0000, 1'b1},  // R3 long off2
    {1'b0, 2'b00, 8'h03, 32'h0,        4'b0001, 1'b0},  // R2 off3
    {1'b1, 2'b01, 8'h0A, 32'h12347F00, 4'b0011, 1'b0},  // R6
    {1'b0, 2'b01, 8'h0A, 32'h0,        4'b0011, 1'b0},  // R9 positive
    {1'b0, 2'b00, 8'h07, 32'h0,        4'b0001, 1'b0},  // R8
    {1'b0, 2'b00, 8'h02, 32'h0,        4'b0010, 1'b0},  // R2 off2
    {1'b0, 2'b10, 8'h0B, 32'h0,        4'b0000, 1'b1}   // R3 long off3
  };

  initial begin
    // Reset state (R11, R4)
    repeat (2) @(negedge clk);
    #1;
    chk("R11 rvalid in reset", {31'h0, cpu_rvalid}, 32'h0);
    chk("R4 no strobe idle", {31'h0, mem_req}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      logic        we;
      logic [1:0]  sz;
      logic [7:0]  a;
      logic [31:0] d;
      logic [3:0]  ebe;
      logic        eerr;
      logic [31:0] eload;
      {we, sz, a, d, ebe, eerr} = VEC[v];
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_size = sz;
      cpu_addr = {24'h0, a}; cpu_wdata = d;
      #1;
      chk("R3 address error", {31'h0, cpu_addr_err}, {31'h0, eerr});
      chk("R4 strobe gating", {31'h0, mem_req}, {31'h0, ~eerr});
      chk("R2 R6 R7 lane enables", {28'h0, mem_be}, {28'h0, ebe});
      if (!eerr) begin
        chk("R1 word address", mem_addr, {24'h0, a[7:2], 2'b00});
        if (we) begin
          chk("R5 R6 R7 store data", mem_wdata, exp_store(sz, d));
          for (int l = 0; l < 4; l++)
            if (ebe[l]) img[a[3:2] * 4 + (3 - l)] = exp_store(sz, d) >> (8 * l);
        end
      end
      eload = exp_load(sz, a);
      @(negedge clk);
      cpu_req = 1'b0;
      #1;
      chk("R11 rvalid", {31'h0, cpu_rvalid}, {31'h0, (!we && !eerr)});
      if (!we && !eerr)
        chk("R8 R9 R10 load data", cpu_rdata, eload);
    end

    // R4: misaligned address without request stays quiet
    @(negedge clk);
    cpu_req = 1'b0; cpu_size = 2'b10; cpu_addr = 32'h3;
    #1;
    chk("R4 idle no error", {31'h0, cpu_addr_err}, 32'h0);
    chk("R4 idle no strobe", {31'h0, mem_req}, 32'h0);

    // R11: reset clears a pending read
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_size = 2'b00; cpu_addr = 32'h1;
    @(negedge clk);
    cpu_req = 1'b0;
    #1;
    chk("R11 rvalid before reset", {31'h0, cpu_rvalid}, 32'h1);
    rst_n = 1'b0;
    #0.5;
    chk("R11 reset clears rvalid", {31'h0, cpu_rvalid}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule